// File: doc/BRIEF.md
# Two-Step Serial Combination Lock Controller

This block is the synchronous controller of a door lock opened by a two-digit combination, each digit 2 bits wide. The user sets the code switches and presses enter, once for each digit. The two correct digits are fixed at build time by parameters and must differ. A correct pair raises the open output. Any wrong digit leads to the error output, but only once the second digit has been entered, so the error light does not show which digit was wrong. Both the open and error conditions hold until reset.

A small compare stage turns the code bus into two match strobes, one for each digit. A control stage holds the state and decides the next state. The state can be stored as a 3-bit binary code or as a 5-bit one-hot vector, selected by a parameter. Both variants show the same 3-bit state code on a debug output. The enter input is expected to be high for one cycle per key press; debouncing is done elsewhere.

Top module: `seq_lock`

## Requirements
- R1: A high `rst` at a rising clock edge puts the state at 000 (both outputs low) from any state, whatever `enter` and `code` do.
- R2: In state 000, low `enter` keeps 000. High `enter` with `code` equal to the first digit (default 2'b01) moves to 001. High `enter` with any other code moves to 101.
- R3: In state 001, low `enter` keeps 001. High `enter` with `code` equal to the second digit (default 2'b11) moves to 010. High `enter` with any other code moves to 110.
- R4: In state 101, low `enter` keeps 101 and high `enter` moves to 110 for every code value.
- R5: States 010 and 110 hold for any `enter` and `code`; only `rst` leaves them.
- R6: `openOut` is high exactly while the state is 010, and `errOut` is high exactly while the state is 110. The two are never high together.
- R7: Each digit is accepted only in its own position: the second digit entered first leads to 101, and the first digit entered second leads to 110.
- R8: With `ONE_HOT`=1 the block gives the same state codes and outputs, cycle for cycle, as with `ONE_HOT`=0.
- R9: `stateDbg` shows the current state as a 3-bit code and only ever shows 000, 001, 010, 101 or 110. Any other stored code returns to 000 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| enter | input | 1 | One-cycle strobe that enters the present code |
| code | input | 2 | Digit set on the switches |
| openOut | output | 1 | Lock released |
| errOut | output | 1 | Wrong combination entered |
| stateDbg | output | 3 | Current state as a 3-bit code |

## Verification
The controller is driven through seven sequences:
- a correct entry;
- a wrong first digit;
- a wrong second digit;
- both digits wrong;
- a reset after a correct first digit;
- a reset after a wrong first digit;
- enter pressed repeatedly while in the open or error state.

The runs also include idle cycles between key presses, so a hold can be told apart from a move. Swapped digits (second digit entered first, first digit entered second) show whether each compare is tied to its own position. A reset given in the same cycle as an enter shows whether reset wins. The binary and one-hot instances run side by side against one behavioural model, so any difference between the two encodings shows up in the very cycle it occurs.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  localparam int STATE_W = 3;
  localparam int HOT_W   = 5;

  localparam logic [STATE_W-1:0] ST_IDLE = 3'b000;
  localparam logic [STATE_W-1:0] ST_ONE  = 3'b001;
  localparam logic [STATE_W-1:0] ST_OPEN = 3'b010;
  localparam logic [STATE_W-1:0] ST_MISS = 3'b101;
  localparam logic [STATE_W-1:0] ST_FAIL = 3'b110;
  localparam logic [STATE_W-1:0] ST_BAD  = 3'b111;

  // Strobes from the compare datapath to the control.
  typedef struct packed {
    logic firstHit;
    logic secondHit;
  } matchStrobe_t;

  function automatic logic [STATE_W-1:0] nextCode(
    input logic [STATE_W-1:0] cur,
    input logic               enter,
    input matchStrobe_t       hit
  );
    logic [STATE_W-1:0] nxt;
    case (cur)
      ST_IDLE: nxt = !enter ? ST_IDLE : (hit.firstHit  ? ST_ONE  : ST_MISS);
      ST_ONE:  nxt = !enter ? ST_ONE  : (hit.secondHit ? ST_OPEN : ST_FAIL);
      ST_MISS: nxt = enter ? ST_FAIL : ST_MISS;
      ST_OPEN: nxt = ST_OPEN;
      ST_FAIL: nxt = ST_FAIL;
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/seq_lock_match.sv
module seq_lock_match
  import seq_lock_pkg::*;
#(
  parameter int                CODE_W       = 2,
  parameter logic [CODE_W-1:0] FIRST_DIGIT  = 2'b01,
  parameter logic [CODE_W-1:0] SECOND_DIGIT = 2'b11
) (
  input  logic [CODE_W-1:0] code,
  output matchStrobe_t      hit
);

  localparam int N_DIGITS = 2;
  localparam logic [N_DIGITS*CODE_W-1:0] DIGITS = {FIRST_DIGIT, SECOND_DIGIT};

  logic [N_DIGITS-1:0] eqVec;

  for (genvar d = 0; d < N_DIGITS; d++) begin : g_cmp
    assign eqVec[d] = (code == DIGITS[d*CODE_W +: CODE_W]);
  end

  assign hit.firstHit  = eqVec[1];
  assign hit.secondHit = eqVec[0];

endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enter,
  input  matchStrobe_t       hit,
  output logic [STATE_W-1:0] stateCode
);

  if (ONE_HOT) begin : g_hot
    logic [HOT_W-1:0]   hotQ;
    logic [HOT_W-1:0]   hotD;
    logic [STATE_W-1:0] curCode;
    logic [STATE_W-1:0] nxtCode;

    always_comb begin
      case (hotQ)
        5'b00001: curCode = ST_IDLE;
        5'b00010: curCode = ST_ONE;
        5'b00100: curCode = ST_OPEN;
        5'b01000: curCode = ST_MISS;
        5'b10000: curCode = ST_FAIL;
        default:  curCode = ST_BAD;
      endcase
    end

    assign nxtCode = nextCode(curCode, enter, hit);

    always_comb begin
      case (nxtCode)
        ST_ONE:  hotD = 5'b00010;
        ST_OPEN: hotD = 5'b00100;
        ST_MISS: hotD = 5'b01000;
        ST_FAIL: hotD = 5'b10000;
        default: hotD = 5'b00001;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) hotQ <= 5'b00001;
      else     hotQ <= hotD;
    end

    assign stateCode = curCode;
  end else begin : g_bin
    logic [STATE_W-1:0] codeQ;

    always_ff @(posedge clk) begin
      if (rst) codeQ <= ST_IDLE;
      else     codeQ <= nextCode(codeQ, enter, hit);
    end

    assign stateCode = codeQ;
  end

endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
#(
  parameter int                CODE_W       = 2,
  parameter logic [CODE_W-1:0] FIRST_DIGIT  = 2'b01,
  parameter logic [CODE_W-1:0] SECOND_DIGIT = 2'b11,
  parameter bit                ONE_HOT      = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic [CODE_W-1:0] code,
  output logic              openOut,
  output logic              errOut,
  output logic [2:0]        stateDbg
);

  matchStrobe_t       hit;
  logic [STATE_W-1:0] stateCode;

  seq_lock_match #(
    .CODE_W      (CODE_W),
    .FIRST_DIGIT (FIRST_DIGIT),
    .SECOND_DIGIT(SECOND_DIGIT)
  ) u_match (
    .code(code),
    .hit (hit)
  );

  seq_lock_ctrl #(
    .ONE_HOT(ONE_HOT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enter    (enter),
    .hit      (hit),
    .stateCode(stateCode)
  );

  assign openOut  = (stateCode == ST_OPEN);
  assign errOut   = (stateCode == ST_FAIL);
  assign stateDbg = stateCode;

endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk (
  input logic       clk,
  input logic       rst,
  input logic       enter,
  input logic [1:0] code,
  input logic       openOut,
  input logic       errOut,
  input logic [2:0] stateDbg
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (stateDbg == 3'b000) && !openOut && !errOut); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (stateDbg == 3'b000 && !enter) |=> stateDbg == 3'b000); // R2
  AST_ONE_HOLD: assert property (@(posedge clk) disable iff (rst) (stateDbg == 3'b001 && !enter) |=> stateDbg == 3'b001); // R3
  AST_MISS_TO_FAIL: assert property (@(posedge clk) disable iff (rst) (stateDbg == 3'b101 && enter) |=> errOut); // R4
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst) openOut |=> openOut); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) errOut |=> errOut); // R5
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst) !(openOut && errOut)); // R6
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    stateDbg == 3'b000 || stateDbg == 3'b001 || stateDbg == 3'b010 ||
    stateDbg == 3'b101 || stateDbg == 3'b110); // R9

endmodule

bind seq_lock seq_lock_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .enter   (enter),
  .code    (code),
  .openOut (openOut),
  .errOut  (errOut),
  .stateDbg(stateDbg)
);

// File: tb/seq_lock_bench.sv
`timescale 1ns/1ps
module seq_lock_bench;

  localparam logic [1:0] DIG_A = 2'b01;
  localparam logic [1:0] DIG_B = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter = 1'b0;
  logic [1:0] code = 2'b00;
  logic       openB, errB, openH, errH;
  logic [2:0] dbgB, dbgH;

  int checks = 0;
  int failures = 0;
  int refState = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seq_lock #(.FIRST_DIGIT(DIG_A), .SECOND_DIGIT(DIG_B), .ONE_HOT(1'b0)) u_seq_lock (
    .clk(clk), .rst(rst), .enter(enter), .code(code),
    .openOut(openB), .errOut(errB), .stateDbg(dbgB)
  );

  seq_lock #(.FIRST_DIGIT(DIG_A), .SECOND_DIGIT(DIG_B), .ONE_HOT(1'b1)) u_seq_lock_oh (
    .clk(clk), .rst(rst), .enter(enter), .code(code),
    .openOut(openH), .errOut(errH), .stateDbg(dbgH)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "bin stateDbg", int'(dbgB), refState);
    check(tag, "bin openOut", int'(openB), int'(refState == 2));
    check(tag, "bin errOut", int'(errB), int'(refState == 6));
    check({tag, "/R8"}, "onehot stateDbg", int'(dbgH), refState);
    check({tag, "/R8"}, "onehot openOut", int'(openH), int'(refState == 2));
    check({tag, "/R8"}, "onehot errOut", int'(errH), int'(refState == 6));
    check("R9", "legal code", int'(dbgB == 3'd0 || dbgB == 3'd1 || dbgB == 3'd2 ||
                                   dbgB == 3'd5 || dbgB == 3'd6), 1);
  endtask

  // One cycle: drive at a falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(input logic r, input logic e, input logic [1:0] c, input string tag);
    rst = r; enter = e; code = c;
    @(posedge clk);
    if (r) refState = 0;
    else begin
      case (refState)
        0: if (e) refState = (c == DIG_A) ? 1 : 5;
        1: if (e) refState = (c == DIG_B) ? 2 : 6;
        5: if (e) refState = 6;
        2, 6: refState = refState;
        default: refState = 0;
      endcase
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, 2'b00, "R1");
    step(1'b1, 1'b1, DIG_A, "R1");
    // (g) successful entry with idle gaps
    step(1'b0, 1'b0, DIG_A, "R2");
    step(1'b0, 1'b1, DIG_A, "R2");
    step(1'b0, 1'b0, DIG_B, "R3");
    step(1'b0, 1'b0, 2'b10, "R3");
    step(1'b0, 1'b1, DIG_B, "R3");
    step(1'b0, 1'b0, 2'b00, "R6");
    // (f) enter in open state
    step(1'b0, 1'b1, DIG_A, "R5");
    step(1'b0, 1'b1, 2'b00, "R5");
    step(1'b1, 1'b0, 2'b00, "R1");
    // (a) first digit wrong
    step(1'b0, 1'b1, 2'b10, "R2");
    step(1'b0, 1'b0, DIG_B, "R4");
    step(1'b0, 1'b1, DIG_B, "R4");
    // (f) enter in error state
    step(1'b0, 1'b1, DIG_A, "R5");
    step(1'b0, 1'b1, DIG_B, "R5");
    step(1'b0, 1'b0, 2'b00, "R6");
    step(1'b1, 1'b0, 2'b00, "R1");
    // (b) second digit wrong
    step(1'b0, 1'b1, DIG_A, "R2");
    step(1'b0, 1'b1, 2'b00, "R3");
    step(1'b1, 1'b0, 2'b00, "R1");
    // (c) both digits wrong
    step(1'b0, 1'b1, 2'b00, "R2");
    step(1'b0, 1'b1, 2'b00, "R4");
    step(1'b1, 1'b0, 2'b00, "R1");
    // (d) reset after correct first digit
    step(1'b0, 1'b1, DIG_A, "R2");
    step(1'b1, 1'b1, DIG_B, "R1");
    step(1'b0, 1'b0, DIG_B, "R2");
    // (e) reset after wrong first digit (second digit entered first)
    step(1'b0, 1'b1, DIG_B, "R7");
    step(1'b1, 1'b0, 2'b00, "R1");
    // first digit entered in second place
    step(1'b0, 1'b1, DIG_A, "R7");
    step(1'b0, 1'b1, DIG_A, "R7");
    step(1'b1, 1'b0, 2'b00, "R1");
    // wrong first digit then every code at the second press
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b1, 2'b10, "R2");
      step(1'b0, 1'b1, 2'(k), "R4");
      step(1'b1, 1'b0, 2'b00, "R1");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule